// File: doc/BRIEF.md
# Instruction Result Memoization Table

This block remembers the outcome of executed instructions so that a later instance of the same computation can skip the execution unit. Every stored entry records which instruction produced it, the values of its two source operands and the result. When an instruction is about to issue, the core presents its address, opcode and operand values on the lookup port. If an entry matches all of them exactly, the block reports a hit and supplies the stored result in the same cycle.

When an instruction that did not hit completes, the core presents it on the insert port. Instructions that touch memory or have side effects are flagged by the core and are never stored. The table is set-associative and indexed by the low bits of the instruction address. Its storage is meant to be carved out of an on-chip cache array that has been partitioned for this use. When that partition is handed back to the cache, a single invalidate pulse empties the table.

Top module: `reuse_buffer`

## Requirements
- R1: After reset, every entry is empty, and any lookup returns `lk_hit` = 0 and `lk_result` = 0.
- R2: A lookup hits only when a valid entry in the set chosen by the low log2(SETS) bits of `lk_pc` holds the same upper address bits, the same opcode, the same `src_a` and the same `src_b`. The hit and its stored result appear combinationally in the same cycle. On a miss, or when `lk_valid` is 0, `lk_hit` is 0 and `lk_result` is 0.
- R3: An insert with `ins_side_eff` = 1 is discarded and leaves the table unchanged.
- R4: Inserting an instruction whose address, opcode and operands already match an entry overwrites that entry's result and occupies no extra way. At most one way in a set ever matches a given key.
- R5: An insert into a set with an empty way uses an empty way. When the set is full, it replaces the way that was least recently inserted or refreshed. Lookups do not change recency.
- R6: When an insert and a lookup fall in the same cycle, the lookup sees the contents from before the insert. The new entry is visible from the cycle after the insert's clock edge.
- R7: Asserting `inv_all` for one cycle empties every entry at the next clock edge. An insert presented in that same cycle is dropped.
- R8: Inserts into one set never evict or alter entries in another set.
- R9: Two instructions that share a set but differ in their upper address bits are distinct, even when their opcode and operands are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Empty the whole table at the next edge |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | PC_W | Address of the issuing instruction |
| lk_opc | input | OPC_W | Opcode of the issuing instruction |
| lk_src_a | input | DATA_W | First operand value |
| lk_src_b | input | DATA_W | Second operand value |
| lk_hit | output | 1 | A stored entry matches the lookup |
| lk_result | output | DATA_W | Stored result on a hit, zero otherwise |
| ins_valid | input | 1 | Insert request present |
| ins_side_eff | input | 1 | Instruction is a load, a store or has side effects |
| ins_pc | input | PC_W | Address of the completing instruction |
| ins_opc | input | OPC_W | Opcode of the completing instruction |
| ins_src_a | input | DATA_W | First operand value |
| ins_src_b | input | DATA_W | Second operand value |
| ins_result | input | DATA_W | Computed result to store |

## Verification
The single-match and recency checks assume that the table can be changed only through its own insert and invalidate paths. They also assume that the core never drives an insert whose fields are unknown. The stimulus always drives every insert field with defined values and raises each request for exactly one cycle. It changes inputs only on the falling clock edge. Eviction is exercised in a single set with addresses that differ only above the index bits, so the expected victim follows directly from the order of the inserts.

// File: rtl/irb_pkg.sv
package irb_pkg;
  parameter int OPC_W  = 8;
  parameter int DATA_W = 32;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [DATA_W-1:0] src_a;
    logic [DATA_W-1:0] src_b;
  } irb_key_t;
endpackage

// File: rtl/irb_tag_match.sv
module irb_tag_match
  import irb_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 28,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tag_i,
  input  irb_key_t [WAYS-1:0]         key_i,
  input  logic [TAG_W-1:0]            probe_tag,
  input  irb_key_t                    probe_key,
  output logic                        any_o,
  output logic [WAY_W-1:0]            way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tag_i[w] == probe_tag) && (key_i[w] == probe_key);
  end

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) way_o = WAY_W'(w);
    end
  end

  assign any_o = |match;

  // R4: stored keys are unique inside a set
  assert_single_way_R4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match));
endmodule

// File: rtl/irb_lru.sv
module irb_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             touch_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q, age_d;
  logic [WAYS-1:0] mru_vec;

  always_comb begin
    age_d = age_q;
    if (clr_i) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_d[s][w] = WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == way_i) age_d[set_i][w] = '0;
        else if (age_q[set_i][w] < age_q[set_i][way_i]) age_d[set_i][w] = age_q[set_i][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
    end else if (clr_i || touch_i) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    victim_o = '0;
    mru_vec  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[set_i][w] == WAY_W'(WAYS-1)) victim_o = WAY_W'(w);
      mru_vec[w] = (age_q[set_i][w] == '0);
    end
  end

  // R5: recency order stays a permutation, exactly one newest way per set
  assert_one_newest_R5: assert property (@(posedge clk) disable iff (!rst_n) $countones(mru_vec) == 1);
endmodule

// File: rtl/reuse_buffer.sv
module reuse_buffer
  import irb_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = PC_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              lk_valid,
  input  logic [PC_W-1:0]   lk_pc,
  input  logic [OPC_W-1:0]  lk_opc,
  input  logic [DATA_W-1:0] lk_src_a,
  input  logic [DATA_W-1:0] lk_src_b,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_result,
  input  logic              ins_valid,
  input  logic              ins_side_eff,
  input  logic [PC_W-1:0]   ins_pc,
  input  logic [OPC_W-1:0]  ins_opc,
  input  logic [DATA_W-1:0] ins_src_a,
  input  logic [DATA_W-1:0] ins_src_b,
  input  logic [DATA_W-1:0] ins_result
);
  logic [SETS-1:0][WAYS-1:0]  valid_q, valid_d;
  logic [WAYS-1:0][TAG_W-1:0] tag_q [SETS];
  irb_key_t [WAYS-1:0]        key_q [SETS];
  logic [DATA_W-1:0]          res_q [SETS][WAYS];

  logic [SET_W-1:0] lk_set, ins_set;
  logic [TAG_W-1:0] lk_tag, ins_tag;
  irb_key_t         lk_key, ins_key;
  logic             lk_any, ins_any, free_any, ins_ok;
  logic [WAY_W-1:0] lk_way, ins_way, free_way, victim, wr_way;

  assign lk_set  = lk_pc[SET_W-1:0];
  assign lk_tag  = lk_pc[PC_W-1:SET_W];
  assign lk_key  = '{opc: lk_opc, src_a: lk_src_a, src_b: lk_src_b};
  assign ins_set = ins_pc[SET_W-1:0];
  assign ins_tag = ins_pc[PC_W-1:SET_W];
  assign ins_key = '{opc: ins_opc, src_a: ins_src_a, src_b: ins_src_b};
  assign ins_ok  = ins_valid && !ins_side_eff && !inv_all;

  irb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_lk_match (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_q[lk_set]), .tag_i(tag_q[lk_set]),
    .key_i(key_q[lk_set]), .probe_tag(lk_tag), .probe_key(lk_key),
    .any_o(lk_any), .way_o(lk_way));

  irb_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_ins_match (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_q[ins_set]), .tag_i(tag_q[ins_set]),
    .key_i(key_q[ins_set]), .probe_tag(ins_tag), .probe_key(ins_key),
    .any_o(ins_any), .way_o(ins_way));

  irb_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
    .clk(clk), .rst_n(rst_n), .clr_i(inv_all), .touch_i(ins_ok),
    .set_i(ins_set), .way_i(wr_way), .victim_o(victim));

  // lookup reads registered state only, so a same-cycle insert is not seen
  assign lk_hit    = lk_valid && lk_any;
  assign lk_result = lk_hit ? res_q[lk_set][lk_way] : '0;

  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!valid_q[ins_set][w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    wr_way = ins_any ? ins_way : (free_any ? free_way : victim);
  end

  always_comb begin
    valid_d = valid_q;
    if (inv_all) valid_d = '0;
    else if (ins_ok) valid_d[ins_set][wr_way] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (inv_all || ins_ok) valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (ins_ok) begin
      tag_q[ins_set][wr_way] <= ins_tag;
      key_q[ins_set][wr_way] <= ins_key;
      res_q[ins_set][wr_way] <= ins_result;
    end
  end

  // R7: one invalidate pulse empties the table
  assert_inv_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0));
  // R3: side-effecting instructions never allocate
  assert_side_eff_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_side_eff && !inv_all) |=> $stable(valid_q));
  // R4: an accepted insert adds at most one entry
  assert_grow_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ok |=> ($countones(valid_q) == $past($countones(valid_q)) ||
                $countones(valid_q) == $past($countones(valid_q)) + 1));
endmodule

// File: tb/test_reuse_buffer.sv
module test_reuse_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inv_all = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic [7:0]  lk_opc = '0;
  logic [31:0] lk_src_a = '0, lk_src_b = '0;
  logic        lk_hit;
  logic [31:0] lk_result;
  logic        ins_valid = 1'b0, ins_side_eff = 1'b0;
  logic [31:0] ins_pc = '0;
  logic [7:0]  ins_opc = '0;
  logic [31:0] ins_src_a = '0, ins_src_b = '0, ins_result = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  reuse_buffer i_reuse_buffer (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_opc(lk_opc), .lk_src_a(lk_src_a),
    .lk_src_b(lk_src_b), .lk_hit(lk_hit), .lk_result(lk_result),
    .ins_valid(ins_valid), .ins_side_eff(ins_side_eff), .ins_pc(ins_pc),
    .ins_opc(ins_opc), .ins_src_a(ins_src_a), .ins_src_b(ins_src_b),
    .ins_result(ins_result));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_insert(input logic [31:0] pc, input logic [7:0] opc,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] res, input bit se);
    @(negedge clk);
    ins_valid = 1'b1; ins_side_eff = se; ins_pc = pc; ins_opc = opc;
    ins_src_a = a; ins_src_b = b; ins_result = res;
    @(posedge clk);
    #1 ins_valid = 1'b0; ins_side_eff = 1'b0;
  endtask

  task automatic look(input logic [31:0] pc, input logic [7:0] opc,
                      input logic [31:0] a, input logic [31:0] b, input bit v,
                      input bit exp_hit, input logic [31:0] exp_res, input string req);
    @(negedge clk);
    lk_valid = v; lk_pc = pc; lk_opc = opc; lk_src_a = a; lk_src_b = b;
    #1;
    chk(lk_hit == exp_hit, {req, " hit"}, {31'b0, lk_hit}, {31'b0, exp_hit});
    chk(lk_result == exp_res, {req, " result"}, lk_result, exp_res);
    lk_valid = 1'b0;
  endtask

  task automatic do_inv();
    @(negedge clk);
    inv_all = 1'b1;
    @(posedge clk);
    #1 inv_all = 1'b0;
  endtask

  task automatic t_reset();
    look(32'h0, 8'h0, 32'h0, 32'h0, 1'b1, 1'b0, 32'h0, "R1 empty after reset");
  endtask

  task automatic t_match();
    do_insert(32'h100, 8'h03, 32'd5, 32'd7, 32'd12, 1'b0);
    look(32'h100, 8'h03, 32'd5, 32'd7, 1'b1, 1'b1, 32'd12, "R2 exact match");
    look(32'h100, 8'h04, 32'd5, 32'd7, 1'b1, 1'b0, 32'd0, "R2 opcode differs");
    look(32'h100, 8'h03, 32'd6, 32'd7, 1'b1, 1'b0, 32'd0, "R2 src_a differs");
    look(32'h100, 8'h03, 32'd5, 32'd8, 1'b1, 1'b0, 32'd0, "R2 src_b differs");
    look(32'h100, 8'h03, 32'd5, 32'd7, 1'b0, 1'b0, 32'd0, "R2 no request");
    look(32'h110, 8'h03, 32'd5, 32'd7, 1'b1, 1'b0, 32'd0, "R9 other pc same set");
  endtask

  task automatic t_side_eff();
    do_insert(32'h205, 8'h10, 32'd1, 32'd2, 32'd99, 1'b1);
    look(32'h205, 8'h10, 32'd1, 32'd2, 1'b1, 1'b0, 32'd0, "R3 side effect dropped");
  endtask

  task automatic t_replace();
    do_inv();
    for (int i = 1; i <= 4; i++)
      do_insert(32'(i * 16), 8'h20, 32'(i), 32'd0, 32'(100 + i), 1'b0);
    do_insert(32'h50, 8'h20, 32'd5, 32'd0, 32'd105, 1'b0);
    look(32'h10, 8'h20, 32'd1, 32'd0, 1'b1, 1'b0, 32'd0, "R5 oldest evicted");
    look(32'h50, 8'h20, 32'd5, 32'd0, 1'b1, 1'b1, 32'd105, "R5 new entry present");
    look(32'h20, 8'h20, 32'd2, 32'd0, 1'b1, 1'b1, 32'd102, "R5 others kept");
    do_insert(32'h20, 8'h20, 32'd2, 32'd0, 32'd222, 1'b0);
    look(32'h20, 8'h20, 32'd2, 32'd0, 1'b1, 1'b1, 32'd222, "R4 refreshed result");
    look(32'h40, 8'h20, 32'd4, 32'd0, 1'b1, 1'b1, 32'd104, "R4 refresh took no way");
    do_insert(32'h60, 8'h20, 32'd6, 32'd0, 32'd106, 1'b0);
    look(32'h30, 8'h20, 32'd3, 32'd0, 1'b1, 1'b0, 32'd0, "R5 refresh changed victim");
    look(32'h20, 8'h20, 32'd2, 32'd0, 1'b1, 1'b1, 32'd222, "R5 refreshed entry kept");
    look(32'h60, 8'h20, 32'd6, 32'd0, 1'b1, 1'b1, 32'd106, "R5 newest present");
  endtask

  task automatic t_sets();
    for (int i = 1; i <= 5; i++)
      do_insert(32'(i * 16 + 3), 8'h30, 32'(i), 32'd1, 32'(300 + i), 1'b0);
    look(32'h40, 8'h20, 32'd4, 32'd0, 1'b1, 1'b1, 32'd104, "R8 other set untouched");
    look(32'h50, 8'h20, 32'd5, 32'd0, 1'b1, 1'b1, 32'd105, "R8 other set untouched 2");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    ins_valid = 1'b1; ins_pc = 32'h85; ins_opc = 8'h41;
    ins_src_a = 32'd9; ins_src_b = 32'd9; ins_result = 32'd81;
    lk_valid = 1'b1; lk_pc = 32'h85; lk_opc = 8'h41; lk_src_a = 32'd9; lk_src_b = 32'd9;
    #1 chk(lk_hit == 1'b0, "R6 pre-insert view", {31'b0, lk_hit}, 32'd0);
    @(posedge clk);
    #1 ins_valid = 1'b0;
    chk(lk_hit == 1'b1 && lk_result == 32'd81, "R6 visible next cycle", lk_result, 32'd81);
    lk_valid = 1'b0;
  endtask

  task automatic t_inv();
    @(negedge clk);
    inv_all = 1'b1;
    ins_valid = 1'b1; ins_pc = 32'h77; ins_opc = 8'h55;
    ins_src_a = 32'd3; ins_src_b = 32'd4; ins_result = 32'd7;
    @(posedge clk);
    #1 inv_all = 1'b0; ins_valid = 1'b0;
    look(32'h77, 8'h55, 32'd3, 32'd4, 1'b1, 1'b0, 32'd0, "R7 same-cycle insert dropped");
    look(32'h60, 8'h20, 32'd6, 32'd0, 1'b1, 1'b0, 32'd0, "R7 entry cleared");
    look(32'h85, 8'h41, 32'd9, 32'd9, 1'b1, 1'b0, 32'd0, "R7 entry cleared 2");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_match();
    t_side_eff();
    t_replace();
    t_sets();
    t_same_cycle();
    t_inv();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule